// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is a memory-mapped master for a single-wire, open-drain serial bus. Software loads a byte into the transmit register, then writes the control register with a start bit and a direction. The block serialises the byte least significant bit first into fixed-length time slots. In the other direction it opens read slots, samples the line, and assembles the received byte. A command that combines the start bit with a break bit sends a long low pulse. The block then listens for a slave that pulls the line low in reply and records that response as a presence flag. A single-bit mode moves one slot instead of eight.

Completion of each operation sets a flag in an interrupt status register, which clears itself when read. When the interrupt enable bit is set, the interrupt output follows those flags. Software can start a soft reset through the system configuration register and watch its completion in the system status register. The pad is driven open-drain: the block only outputs a drive-low request, and the line input passes through a synchroniser before it is sampled. All timings are counted in clock cycles and set by parameters.

Top module: `swb_master`

## Requirements
- R1: After reset the control, interrupt status, transmit and receive registers read 0x00. System status reads 0x01, the revision register reads the REV parameter, and `irq` and `line_drive_low` are 0.
- R2: Writing control with bit4 (start) = 1 and bit1 (direction) = 0 sends the transmit byte least significant bit first in 8 slots of T_SLOT cycles. Each slot begins with a low pulse of T_LOW1 cycles for a 1 and T_LOW0 cycles for a 0. On completion, interrupt status bit2 is set, and the line is never driven while the block is idle.
- R3: Writing control with bit4 = 1 and bit1 = 1 runs 8 read slots. Each slot drives the line low for T_LOW1 cycles and samples the synchronised line T_SAMP cycles after the slot starts. The bits are stored least significant bit first in receive data (offset 0x08), and interrupt status bit1 is set.
- R4: With control bit7 (single) = 1, a start runs exactly one slot. A transmit takes bit0 of transmit data. A receive places the bit in bit0 of receive data, with bits 7:1 reading 0.
- R5: Writing control with bit2 (break) and bit4 both 1 drives the line low for T_BREAK cycles, then releases it for a T_PRES-cycle listening window. Control bit3 reads 1 exactly when a slave held the line low inside that window. At the end, interrupt status bit0 is set.
- R6: Bit4, and bit2 when it was set, read 0 once the operation finishes. Bits 7, 6, 5 and 1 keep the values written.
- R7: A read of interrupt status (offset 0x10) returns the pending flags and leaves all of them cleared.
- R8: `irq` is 1 exactly when control bit6 (interrupt enable) is 1 and at least one interrupt status flag is set, one cycle after that condition arises.
- R9: A control write while an operation is in progress has no effect on the control register, and it does not start a second operation.
- R10: Writing 1 to system config bit1 (offset 0x14) starts a soft reset. For RST_CYC cycles, system status bit0 reads 0 and config bit1 reads 1. The engine stops and releases the line, and the control, interrupt, transmit and receive registers clear. Config bit0 (auto-idle) keeps the value written.
- R11: Registers sit at byte offsets 0x00 revision, 0x04 transmit, 0x08 receive, 0x0C control, 0x10 interrupt status, 0x14 system config and 0x18 system status. Read data appears on `bus_rdata` one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| line_in | input | 1 | Level of the bus line (asynchronous) |
| line_drive_low | output | 1 | 1 = pull the line low, 0 = release |
| irq | output | 1 | Interrupt request |

## Verification
The bench shortens every timing so that many operations fit in a short run. It uses T_BREAK=40, T_PRES=30, T_SLOT=24, T_LOW1=3, T_LOW0=12, T_SAMP=9 and RST_CYC=6. These values keep the pulse lengths for a 1 and a 0 distinct enough for a slave model to decode each bit from the width of the low pulse. They leave room inside a slot for a model slave to hold the line low past the sample point. They also make it possible to abort an operation with a soft reset in the middle of a byte.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int BYTE_W = 8;

  // control bit positions
  localparam int CB_SINGLE = 7;
  localparam int CB_IEN    = 6;
  localparam int CB_CLKEN  = 5;
  localparam int CB_GO     = 4;
  localparam int CB_PRES   = 3;
  localparam int CB_INIT   = 2;
  localparam int CB_DIR    = 1;

  // interrupt status bit positions
  localparam int IB_TX  = 2;
  localparam int IB_RX  = 1;
  localparam int IB_TMO = 0;

  // writable control bits (presence and bit0 are not stored)
  localparam logic [BYTE_W-1:0] CTRL_WMASK = 8'hF6;

  typedef enum logic [1:0] {OP_NONE, OP_TX, OP_RX, OP_BRK} op_kind_t;
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/swb_engine.sv
module swb_engine
  import swb_pkg::*;
#(
  parameter int T_BREAK     = 9500,
  parameter int T_PRES      = 9500,
  parameter int T_SLOT      = 9500,
  parameter int T_LOW1      = 1500,
  parameter int T_LOW0      = 5000,
  parameter int T_SAMP      = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              start,
  input  logic              st_brk,
  input  logic              st_dir,
  input  logic              st_single,
  input  logic [BYTE_W-1:0] st_tx,
  input  logic              line_s,
  output logic              busy,
  output logic              done,
  output op_kind_t          done_kind,
  output logic [BYTE_W-1:0] rx_val,
  output logic              pres,
  output logic              drive_low
);
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_MAX = max2(max2(T_BREAK, T_PRES), max2(T_SLOT, max2(T_LOW0, T_SAMP)));
  localparam int CW    = $clog2(T_MAX + 2);
  localparam int GUARD = SYNC_STAGES + 1;

  localparam logic [CW-1:0] C_BRK_END  = CW'(T_BREAK - 1);
  localparam logic [CW-1:0] C_PRES_END = CW'(T_PRES - 1);
  localparam logic [CW-1:0] C_SLOT_END = CW'(T_SLOT - 1);
  localparam logic [CW-1:0] C_SAMP     = CW'(T_SAMP);
  localparam logic [CW-1:0] C_GUARD    = CW'(GUARD);
  localparam logic [CW-1:0] C_LOW1     = CW'(T_LOW1);
  localparam logic [CW-1:0] C_LOW0     = CW'(T_LOW0);
  localparam logic [2:0]    LAST_IDX   = 3'(BYTE_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_BLOW, S_LISTEN, S_SLOT} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [2:0]        bit_i;
  logic [BYTE_W-1:0] tx_sh, rx_sh;
  logic              dir_q, single_q, drv_q, pres_q, done_q;
  op_kind_t          kind_q;

  logic [CW-1:0] cnt_nxt, low_len;
  logic          last_bit;

  assign cnt_nxt  = cnt + 1'b1;
  assign low_len  = (dir_q || tx_sh[0]) ? C_LOW1 : C_LOW0;
  assign last_bit = single_q || (bit_i == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bit_i    <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      dir_q    <= 1'b0;
      single_q <= 1'b0;
      drv_q    <= 1'b0;
      pres_q   <= 1'b0;
      done_q   <= 1'b0;
      kind_q   <= OP_NONE;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            cnt      <= '0;
            bit_i    <= '0;
            drv_q    <= 1'b1;
            dir_q    <= st_dir;
            single_q <= st_single;
            tx_sh    <= st_tx;
            rx_sh    <= '0;
            if (st_brk) begin
              st     <= S_BLOW;
              pres_q <= 1'b0;
            end else begin
              st <= S_SLOT;
            end
          end
        end
        S_BLOW: begin
          cnt <= cnt_nxt;
          if (cnt == C_BRK_END) begin
            st    <= S_LISTEN;
            cnt   <= '0;
            drv_q <= 1'b0;
          end
        end
        S_LISTEN: begin
          cnt <= cnt_nxt;
          // skip the cycles in which the synchroniser still shows our own pulse
          if (cnt >= C_GUARD && !line_s) pres_q <= 1'b1;
          if (cnt == C_PRES_END) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            kind_q <= OP_BRK;
          end
        end
        S_SLOT: begin
          cnt   <= cnt_nxt;
          drv_q <= (cnt_nxt < low_len);
          if (dir_q && cnt == C_SAMP) rx_sh <= {line_s, rx_sh[BYTE_W-1:1]};
          if (cnt == C_SLOT_END) begin
            if (last_bit) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
              kind_q <= dir_q ? OP_RX : OP_TX;
              drv_q  <= 1'b0;
            end else begin
              cnt   <= '0;
              bit_i <= bit_i + 1'b1;
              tx_sh <= {1'b0, tx_sh[BYTE_W-1:1]};
              drv_q <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE) || done_q;
  assign done      = done_q;
  assign done_kind = kind_q;
  assign rx_val    = single_q ? {{(BYTE_W-1){1'b0}}, rx_sh[BYTE_W-1]} : rx_sh;
  assign pres      = pres_q;
  assign drive_low = drv_q;
endmodule

// File: rtl/swb_regs.sv
module swb_regs
  import swb_pkg::*;
#(
  parameter int                ADDR_W  = 5,
  parameter logic [BYTE_W-1:0] REV     = 8'h21,
  parameter int                RST_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  op_kind_t          eng_kind,
  input  logic [BYTE_W-1:0] eng_rx,
  input  logic              eng_pres,
  output logic              start,
  output logic              st_brk,
  output logic              st_dir,
  output logic              st_single,
  output logic [BYTE_W-1:0] st_tx,
  output logic              srst_act,
  output logic              ien,
  output logic              int_any
);
  localparam int SCW = $clog2(RST_CYC + 1);

  localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TXD   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RXD   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_INT   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_SCFG  = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] A_SSTAT = ADDR_W'(24);

  logic [BYTE_W-1:0] ctrl_q, tx_q, rx_q, rdata_q, rd_mux, ctrl_view;
  logic [2:0]        int_q, int_set, int_nxt;
  logic              autoidle_q;
  logic [SCW-1:0]    srst_cnt;

  logic wr_en, rd_en, wr_ctrl, wr_txd, wr_scfg, rd_int;

  assign srst_act = (srst_cnt != '0);
  assign wr_en    = sel && wr && !srst_act;
  assign rd_en    = sel && !wr;
  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_txd   = wr_en && (addr == A_TXD);
  assign wr_scfg  = wr_en && (addr == A_SCFG);
  assign rd_int   = rd_en && (addr == A_INT);

  assign start     = wr_ctrl && wdata[CB_GO] && !eng_busy;
  assign st_brk    = wdata[CB_INIT];
  assign st_dir    = wdata[CB_DIR];
  assign st_single = wdata[CB_SINGLE];
  assign st_tx     = tx_q;

  always_comb begin
    int_set = '0;
    if (eng_done) begin
      case (eng_kind)
        OP_TX:   int_set[IB_TX]  = 1'b1;
        OP_RX:   int_set[IB_RX]  = 1'b1;
        OP_BRK:  int_set[IB_TMO] = 1'b1;
        default: int_set = '0;
      endcase
    end
    int_nxt = (rd_int ? 3'b000 : int_q) | int_set;
  end

  always_comb begin
    ctrl_view          = ctrl_q;
    ctrl_view[CB_PRES] = eng_pres;
    case (addr)
      A_REV:   rd_mux = REV;
      A_TXD:   rd_mux = tx_q;
      A_RXD:   rd_mux = rx_q;
      A_CTRL:  rd_mux = ctrl_view;
      A_INT:   rd_mux = {{(BYTE_W-3){1'b0}}, int_q};
      A_SCFG:  rd_mux = {{(BYTE_W-2){1'b0}}, srst_act, autoidle_q};
      A_SSTAT: rd_mux = {{(BYTE_W-1){1'b0}}, !srst_act};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      int_q      <= '0;
      rdata_q    <= '0;
      autoidle_q <= 1'b0;
      srst_cnt   <= '0;
    end else begin
      if (srst_act) srst_cnt <= srst_cnt - 1'b1;
      if (rd_en)    rdata_q  <= rd_mux;
      if (wr_txd)   tx_q     <= wdata;
      if (eng_done && eng_kind == OP_RX) rx_q <= eng_rx;
      int_q <= int_nxt;
      if (wr_ctrl && !eng_busy) begin
        ctrl_q <= wdata & CTRL_WMASK;
      end else if (eng_done) begin
        ctrl_q[CB_GO]   <= 1'b0;
        ctrl_q[CB_INIT] <= 1'b0;
      end
      if (wr_scfg) begin
        autoidle_q <= wdata[0];
        if (wdata[1]) begin
          srst_cnt <= SCW'(RST_CYC);
          ctrl_q   <= '0;
          int_q    <= '0;
          tx_q     <= '0;
          rx_q     <= '0;
        end
      end
    end
  end

  assign rdata   = rdata_q;
  assign ien     = ctrl_q[CB_IEN];
  assign int_any = |int_q;
endmodule

// File: rtl/swb_master.sv
module swb_master
  import swb_pkg::*;
#(
  parameter int                ADDR_W      = 5,
  parameter logic [BYTE_W-1:0] REV         = 8'h21,
  parameter int                RST_CYC     = 16,
  parameter int                SYNC_STAGES = 2,
  parameter int                T_BREAK     = 9500,
  parameter int                T_PRES      = 9500,
  parameter int                T_SLOT      = 9500,
  parameter int                T_LOW1      = 1500,
  parameter int                T_LOW0      = 5000,
  parameter int                T_SAMP      = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              line_in,
  output logic              line_drive_low,
  output logic              irq
);
  logic              line_s;
  logic              eng_busy, eng_done, eng_pres;
  op_kind_t          eng_kind;
  logic [BYTE_W-1:0] eng_rx, st_tx;
  logic              start, st_brk, st_dir, st_single;
  logic              srst_act, ien, int_any;
  logic              irq_q;

  swb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  swb_regs #(.ADDR_W(ADDR_W), .REV(REV), .RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst(rst),
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_kind(eng_kind),
    .eng_rx(eng_rx), .eng_pres(eng_pres),
    .start(start), .st_brk(st_brk), .st_dir(st_dir), .st_single(st_single), .st_tx(st_tx),
    .srst_act(srst_act), .ien(ien), .int_any(int_any)
  );

  swb_engine #(
    .T_BREAK(T_BREAK), .T_PRES(T_PRES), .T_SLOT(T_SLOT), .T_LOW1(T_LOW1),
    .T_LOW0(T_LOW0), .T_SAMP(T_SAMP), .SYNC_STAGES(SYNC_STAGES)
  ) u_eng (
    .clk(clk), .rst(rst), .clr(srst_act),
    .start(start), .st_brk(st_brk), .st_dir(st_dir), .st_single(st_single), .st_tx(st_tx),
    .line_s(line_s),
    .busy(eng_busy), .done(eng_done), .done_kind(eng_kind), .rx_val(eng_rx),
    .pres(eng_pres), .drive_low(line_drive_low)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ien && int_any;
  end

  assign irq = irq_q;
endmodule

// File: rtl/swb_master_chk.sv
module swb_master_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              drive_low,
  input logic              irq,
  input logic              busy,
  input logic              done,
  input logic [7:0]        ctrl,
  input logic [2:0]        intf,
  input logic              srst_act,
  input logic              sel,
  input logic              wr,
  input logic [ADDR_W-1:0] addr
);
  logic wr_scfg, rd_int;
  assign wr_scfg = sel && wr && (addr == ADDR_W'(20));
  assign rd_int  = sel && !wr && (addr == ADDR_W'(16));

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !drive_low);

  assert_go_init_clear_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> (!ctrl[4] && !ctrl[2]));

  assert_int_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_int && !done) |=> (intf == 3'b000));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(|intf) && $past(ctrl[6])));

  assert_busy_ctrl_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && !wr_scfg && !srst_act) |=>
      ($stable(ctrl[7:5]) && $stable(ctrl[2:1])));

  assert_srst_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    srst_act |=> (!busy && !drive_low));
endmodule

bind swb_master swb_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .drive_low(line_drive_low), .irq(irq),
  .busy(eng_busy), .done(eng_done), .ctrl(u_regs.ctrl_q), .intf(u_regs.int_q),
  .srst_act(srst_act), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr)
);

// File: tb/tb_swb_master.sv
module tb_swb_master;
  localparam int AW      = 5;
  localparam int BRK     = 40;
  localparam int PRS     = 30;
  localparam int SLT     = 24;
  localparam int L1      = 3;
  localparam int L0      = 12;
  localparam int SMP     = 9;
  localparam int RSTC    = 6;
  localparam logic [7:0] REVV = 8'h21;

  localparam logic [4:0] O_REV = 5'h00, O_TXD = 5'h04, O_RXD = 5'h08, O_CTRL = 5'h0C,
                         O_INT = 5'h10, O_SCFG = 5'h14, O_SSTAT = 5'h18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic line_in, line_drive_low, irq;

  always #10 clk = ~clk;  // 50 MHz

  swb_master #(
    .ADDR_W(AW), .REV(REVV), .RST_CYC(RSTC), .SYNC_STAGES(2),
    .T_BREAK(BRK), .T_PRES(PRS), .T_SLOT(SLT), .T_LOW1(L1), .T_LOW0(L0), .T_SAMP(SMP)
  ) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
    .line_drive_low(line_drive_low), .irq(irq)
  );

  // slave model controls (written only by the main initial block)
  logic       rx_mode = 1'b0;
  logic [7:0] rx_pat  = 8'h00;
  int         rx_base = 0;
  logic       pres_en = 1'b0;

  // monitor state (written only by the monitor)
  int         hold = 0;
  int         run_len = 0;
  int         n_starts = 0;
  int         n_slots = 0;
  int         n_breaks = 0;
  int         bad_len = 0;
  logic [7:0] cap = 8'h00;
  logic       prev_drv = 1'b0;

  assign line_in = !(line_drive_low || (hold != 0));

  always @(negedge clk) begin
    if (!rst) begin
      if (line_drive_low) run_len = run_len + 1;
      if (line_drive_low && !prev_drv) begin
        if (rx_mode && !rx_pat[3'(n_starts - rx_base)]) hold = 16;
        n_starts = n_starts + 1;
      end
      if (!line_drive_low && prev_drv) begin
        if (run_len >= BRK) begin
          n_breaks = n_breaks + 1;
          if (pres_en) hold = 10;
        end else begin
          n_slots = n_slots + 1;
          cap = {(run_len == L1), cap[7:1]};
          if (run_len != L1 && run_len != L0) bad_len = bad_len + 1;
        end
        run_len = 0;
      end else if (hold > 0) begin
        hold = hold - 1;
      end
      prev_drv = line_drive_low;
    end
  end

  int  n_vec = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      bus_read(O_CTRL, v);
      if (!v[4]) return;
    end
    chk(req, 32'hDEAD, 32'h0);
  endtask

  // expected control value after completion: start and break bits fall back
  function automatic logic [7:0] exp_ctrl(input logic [7:0] w, input logic p);
    return (w & 8'hE2) | {4'b0, p, 3'b0};
  endfunction

  function automatic logic [7:0] exp_low(input logic [7:0] v, input int nbits);
    return (nbits == 1) ? {7'b0, v[0]} : v;
  endfunction

  initial begin
    logic [7:0] v, d;
    int s0, b0;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R11: reset state and offsets
    bus_read(O_REV, v);   chk("R11 revision", v, REVV);
    bus_read(O_CTRL, v);  chk("R1 ctrl", v, 8'h00);
    bus_read(O_INT, v);   chk("R1 int", v, 8'h00);
    bus_read(O_RXD, v);   chk("R1 rx", v, 8'h00);
    bus_read(O_TXD, v);   chk("R1 tx", v, 8'h00);
    bus_read(O_SSTAT, v); chk("R1 sysstatus", v, 8'h01);
    chk("R1 irq", irq, 0);
    chk("R1 drive", line_drive_low, 0);

    // R5 break with a responding slave
    pres_en = 1'b1;
    b0 = n_breaks;
    bus_write(O_CTRL, 8'h74);
    wait_idle("R5 break done");
    chk("R5 one break", n_breaks - b0, 1);
    bus_read(O_CTRL, v); chk("R5 R6 ctrl presence", v, exp_ctrl(8'h74, 1'b1));
    chk("R8 irq on", irq, 1);
    bus_read(O_INT, v);  chk("R5 R7 timeout flag", v, 8'h01);
    bus_read(O_INT, v);  chk("R7 cleared", v, 8'h00);
    @(negedge clk);
    chk("R8 irq off", irq, 0);

    // R5 break without a slave
    pres_en = 1'b0;
    bus_write(O_CTRL, 8'h74);
    wait_idle("R5 break2 done");
    bus_read(O_CTRL, v); chk("R5 no presence", v, exp_ctrl(8'h74, 1'b0));
    bus_read(O_INT, v);  chk("R5 timeout flag2", v, 8'h01);

    // R2 transmit bytes, directed then random
    for (int k = 0; k < 8; k++) begin
      d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
      s0 = n_slots;
      bus_write(O_TXD, d);
      bus_write(O_CTRL, 8'h70);
      wait_idle("R2 tx done");
      chk("R2 tx slots", n_slots - s0, 8);
      chk("R2 tx byte", cap, d);
      bus_read(O_CTRL, v); chk("R6 ctrl after tx", v, exp_ctrl(8'h70, 1'b0));
      bus_read(O_INT, v);  chk("R2 tx flag", v, 8'h04);
    end
    chk("R2 pulse widths", bad_len, 0);

    // R3 receive bytes
    rx_mode = 1'b1;
    for (int k = 0; k < 8; k++) begin
      d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
      rx_pat = d;
      rx_base = n_starts;
      bus_write(O_CTRL, 8'h72);
      wait_idle("R3 rx done");
      bus_read(O_RXD, v);  chk("R3 rx byte", v, d);
      bus_read(O_INT, v);  chk("R3 rx flag", v, 8'h02);
      bus_read(O_CTRL, v); chk("R6 ctrl after rx", v, exp_ctrl(8'h72, 1'b0));
    end

    // R4 single-bit receive
    for (int k = 0; k < 2; k++) begin
      rx_pat = (k == 0) ? 8'hFE : 8'h01;
      rx_base = n_starts;
      s0 = n_slots;
      bus_write(O_CTRL, 8'hF2);
      wait_idle("R4 rx1 done");
      chk("R4 rx single slots", n_slots - s0, 1);
      bus_read(O_RXD, v);  chk("R4 rx single bit", v, exp_low(rx_pat, 1));
      bus_read(O_INT, v);  chk("R4 rx single flag", v, 8'h02);
    end
    rx_mode = 1'b0;

    // R4 single-bit transmit
    for (int k = 0; k < 2; k++) begin
      d = (k == 0) ? 8'hFE : 8'h01;
      s0 = n_slots;
      bus_write(O_TXD, d);
      bus_write(O_CTRL, 8'hF0);
      wait_idle("R4 tx1 done");
      chk("R4 tx single slots", n_slots - s0, 1);
      chk("R4 tx single bit", {7'b0, cap[7]}, exp_low(d, 1));
      bus_read(O_INT, v); chk("R4 tx single flag", v, 8'h04);
    end

    // R9 control write during a transfer is ignored
    d = 8'hA5;
    s0 = n_slots;
    bus_write(O_TXD, d);
    bus_write(O_CTRL, 8'h70);
    repeat (30) @(negedge clk);
    bus_write(O_CTRL, 8'h96);
    wait_idle("R9 done");
    chk("R9 slots", n_slots - s0, 8);
    chk("R9 byte intact", cap, d);
    bus_read(O_CTRL, v); chk("R9 ctrl untouched", v, exp_ctrl(8'h70, 1'b0));
    bus_read(O_INT, v);  chk("R9 only tx flag", v, 8'h04);

    // R8 interrupt enable off keeps irq low
    bus_write(O_TXD, 8'h3C);
    bus_write(O_CTRL, 8'h30);
    wait_idle("R8 tx done");
    chk("R8 irq masked", irq, 0);
    bus_read(O_INT, v); chk("R8 flag still set", v, 8'h04);

    // R10 soft reset with auto-idle set, mid-transfer
    bus_write(O_TXD, 8'h0F);
    bus_write(O_CTRL, 8'hE0 | 8'h10);
    repeat (20) @(negedge clk);
    bus_write(O_SCFG, 8'h03);
    bus_read(O_SSTAT, v); chk("R10 reset busy", v, 8'h00);
    bus_read(O_SCFG, v);  chk("R10 cfg during", v, 8'h03);
    chk("R10 line released", line_drive_low, 0);
    repeat (RSTC + 2) @(negedge clk);
    bus_read(O_SSTAT, v); chk("R10 reset done", v, 8'h01);
    bus_read(O_SCFG, v);  chk("R10 cfg after", v, 8'h01);
    bus_read(O_CTRL, v);  chk("R10 ctrl cleared", v, 8'h00);
    bus_read(O_INT, v);   chk("R10 int cleared", v, 8'h00);
    bus_read(O_TXD, v);   chk("R10 tx cleared", v, 8'h00);
    repeat (SLT) @(negedge clk);
    chk("R10 line idle", line_drive_low, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule